// File: doc/BRIEF.md
# Condition-Bit Execute Unit

This block is the integer execute stage of a small core with 16-bit instructions and a single condition/carry flag. On every cycle with `issue` high it takes an operation code, two register operands, a short immediate and the current flag value. One clock later it presents a result word, a flag telling whether that word should be written back, the flag value to carry forward, and a flag-write enable.

The operation set covers carry-aware add and subtract, plain add and subtract, unsigned and signed compares, byte extraction and byte testing, decrement-with-test, leading-zero count, bit mirroring, single-bit generation and low-order masks, a one-bit right shift that pulls the flag into the top bit, rotate-left by an immediate, and single-bit test. Some operations write only the flag. Others write only the result. A few write both. When an operation does not write the flag, `c_new` simply repeats the incoming flag, so the core can always take its next flag state from `c_new`.

Top module: `cbit_alu`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_out`, `res_vld`, `c_new` and `c_we` are all 0.
- R2: Opcode 0 (add with flag): `res_out` = a + b + c_in modulo 2^W, and `c_new` is the carry out of the top bit. Both `res_vld` and `c_we` are 1.
- R3: Opcode 1 (subtract with flag): `res_out` = a - b + c_in - 1 modulo 2^W, and `c_new` is the carry out of a + ~b + c_in, so 1 means no borrow. Both `res_vld` and `c_we` are 1.
- R4: Opcodes 2 and 3 (plain add a+b, plain subtract a-b): `res_vld` is 1, `c_we` is 0 and `c_new` equals the `c_in` that came with the operation.
- R5: Opcode 4 sets `c_new` to (a >= b) unsigned, and opcode 5 sets it to (a < b) signed. Both give `c_we`=1, `res_vld`=0 and `res_out`=0.
- R6: Opcode 6 (byte extract): `res_out` is byte imm[1:0] of a, zero-extended, where byte 0 is bits 7:0. `c_new` is 1 exactly when the whole of a is nonzero. Both `res_vld` and `c_we` are 1.
- R7: Opcode 7 (no-zero-byte test): `c_new` is 1 only when all four bytes of a are nonzero. `c_we`=1 and `res_vld`=0.
- R8: Opcodes 8, 9 and 10 write `res_out` = a - 1 and set `c_new` from that new value being, in signed terms, below 0 (opcode 8), above 0 (opcode 9) or not 0 (opcode 10). Both `res_vld` and `c_we` are 1.
- R9: Opcode 11 returns the number of zero bits above the highest set bit of a, and returns 32 for a zero operand. `res_vld`=1 and `c_we`=0.
- R10: Opcode 12 mirrors a, so bit i moves to bit 31-i. `res_vld`=1 and `c_we`=0.
- R11: Opcode 13 returns 0 when b[5] is 1, and 1 << b[4:0] otherwise. Opcode 14 returns (1 << imm) - 1, which is 0 for imm 0. Both give `res_vld`=1 and `c_we`=0.
- R12: Opcode 15 returns {c_in, a[31:1]} and sets `c_new` to a[0] with `c_we`=1. Opcode 16 rotates a left by imm over all 32 bits with `c_we`=0. Both give `res_vld`=1.
- R13: Opcode 17 sets `c_new` to a[imm] with `c_we`=1 and `res_vld`=0.
- R14: Outputs appear on the clock edge after `issue`. In a cycle without `issue`, and for opcodes 18 to 31, the next outputs are `res_vld`=0, `c_we`=0, `res_out`=0 and `c_new` equal to the previous cycle's `c_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is presented this cycle |
| op_in | input | 5 | Operation code |
| a_in | input | 32 | First operand (destination register value) |
| b_in | input | 32 | Second operand (source register value) |
| imm_in | input | 5 | Immediate shift, bit or byte index |
| c_in | input | 1 | Current condition/carry flag |
| res_out | output | 32 | Registered result word |
| res_vld | output | 1 | Result should be written back |
| c_new | output | 1 | Flag value for the next instruction |
| c_we | output | 1 | Operation wrote the flag |

## Verification
The bench builds the block at its default width of 32 bits. At that width the 5-bit immediate reaches every bit position, so every rotate amount, every bit-test index, every mask length and both the in-range and out-of-range halves of the bit-generate operand can be swept in full. The sweep also issues all 32 opcode codes against a grid of boundary operands (zero, one, sign bit, all ones, mixed bytes) with both flag values. This reaches the carry and borrow edges, the signed/unsigned split of the compares, the zero case of the leading-zero count and the unused opcode codes.

// File: rtl/cbit_pkg.sv
package cbit_pkg;

  typedef enum logic [4:0] {
    OP_ADDC   = 5'd0,
    OP_SUBC   = 5'd1,
    OP_ADDU   = 5'd2,
    OP_SUBU   = 5'd3,
    OP_CMPHS  = 5'd4,
    OP_CMPLT  = 5'd5,
    OP_XBYTE  = 5'd6,
    OP_NZBYTE = 5'd7,
    OP_DECLT  = 5'd8,
    OP_DECGT  = 5'd9,
    OP_DECNE  = 5'd10,
    OP_LZCNT  = 5'd11,
    OP_MIRROR = 5'd12,
    OP_BITGEN = 5'd13,
    OP_LOMASK = 5'd14,
    OP_SHRC   = 5'd15,
    OP_ROTL   = 5'd16,
    OP_BITTST = 5'd17
  } op_e;

  // Per-unit claim and flag outputs; the result word travels separately.
  typedef struct packed {
    logic own;
    logic rv;
    logic cwe;
    logic c;
  } unit_flags_t;

endpackage

// File: rtl/cbit_arith.sv
module cbit_arith
  import cbit_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output unit_flags_t  flg
);

  logic [W:0]   sum;
  logic [W-1:0] b_eff;
  logic         use_c;
  logic [W-1:0] dec;
  op_e          opc;

  assign opc   = op_e'(op);
  assign b_eff = (opc == OP_SUBC || opc == OP_SUBU) ? ~b : b;
  assign use_c = (opc == OP_ADDC || opc == OP_SUBC);
  // Plain subtract is a + ~b + 1; carry-aware forms feed the flag in.
  assign sum   = {1'b0, a} + {1'b0, b_eff}
               + {{W{1'b0}}, (use_c ? cin : (opc == OP_SUBU))};
  assign dec   = a - {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res = '0;
    flg = '0;
    unique case (opc)
      OP_ADDC, OP_SUBC: begin
        res     = sum[W-1:0];
        flg.own = 1'b1;
        flg.rv  = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = sum[W];
      end
      OP_ADDU, OP_SUBU: begin
        res     = sum[W-1:0];
        flg.own = 1'b1;
        flg.rv  = 1'b1;
      end
      OP_CMPHS: begin
        flg.own = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = (a >= b);
      end
      OP_CMPLT: begin
        flg.own = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = ($signed(a) < $signed(b));
      end
      OP_DECLT, OP_DECGT, OP_DECNE: begin
        res     = dec;
        flg.own = 1'b1;
        flg.rv  = 1'b1;
        flg.cwe = 1'b1;
        if (opc == OP_DECLT)      flg.c = dec[W-1];
        else if (opc == OP_DECGT) flg.c = !dec[W-1] && (dec != '0);
        else                      flg.c = (dec != '0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cbit_bitops.sv
module cbit_bitops
  import cbit_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = $clog2(W)
) (
  input  logic [4:0]      op,
  input  logic [W-1:0]    a,
  input  logic [IMMW:0]   bsel,
  input  logic [IMMW-1:0] imm,
  output logic [W-1:0]    res,
  output unit_flags_t     flg
);

  localparam int NB  = W / 8;
  localparam int BSW = $clog2(NB);
  localparam int CW  = $clog2(W + 1);

  op_e          opc;
  logic [W-1:0] mirror;
  logic [CW-1:0] lz;
  logic [W:0]   one_sh;
  logic [W-1:0] lane;
  logic         all_nz;

  assign opc = op_e'(op);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_mirror
      assign mirror[gi] = a[W-1-gi];
    end
  endgenerate

  always_comb begin
    lz = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (a[i]) lz = CW'(W - 1 - i);
    end
  end

  always_comb begin
    all_nz = 1'b1;
    for (int k = 0; k < NB; k++) begin
      if (a[k*8 +: 8] == 8'd0) all_nz = 1'b0;
    end
  end

  assign lane   = (a >> ({{(IMMW-BSW){1'b0}}, imm[BSW-1:0]} * 8)) & {{(W-8){1'b0}}, 8'hFF};
  assign one_sh = {{W{1'b0}}, 1'b1} << imm;

  always_comb begin
    res = '0;
    flg = '0;
    unique case (opc)
      OP_XBYTE: begin
        res     = lane;
        flg.own = 1'b1;
        flg.rv  = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = (a != '0);
      end
      OP_NZBYTE: begin
        flg.own = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = all_nz;
      end
      OP_LZCNT: begin
        res     = W'(lz);
        flg.own = 1'b1;
        flg.rv  = 1'b1;
      end
      OP_MIRROR: begin
        res     = mirror;
        flg.own = 1'b1;
        flg.rv  = 1'b1;
      end
      OP_BITGEN: begin
        res     = bsel[IMMW] ? '0 : (W'(1) << bsel[IMMW-1:0]);
        flg.own = 1'b1;
        flg.rv  = 1'b1;
      end
      OP_LOMASK: begin
        res     = one_sh[W-1:0] - W'(1);
        flg.own = 1'b1;
        flg.rv  = 1'b1;
      end
      OP_BITTST: begin
        flg.own = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = a[imm];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cbit_shift.sv
module cbit_shift
  import cbit_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = $clog2(W)
) (
  input  logic [4:0]      op,
  input  logic [W-1:0]    a,
  input  logic [IMMW-1:0] imm,
  input  logic            cin,
  output logic [W-1:0]    res,
  output unit_flags_t     flg
);

  op_e            opc;
  logic [2*W-1:0] dbl;

  assign opc = op_e'(op);
  // The upper half of the doubled word, shifted left, is the rotation.
  assign dbl = {a, a} << imm;

  always_comb begin
    res = '0;
    flg = '0;
    unique case (opc)
      OP_SHRC: begin
        res     = {cin, a[W-1:1]};
        flg.own = 1'b1;
        flg.rv  = 1'b1;
        flg.cwe = 1'b1;
        flg.c   = a[0];
      end
      OP_ROTL: begin
        res     = dbl[2*W-1:W];
        flg.own = 1'b1;
        flg.rv  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cbit_alu.sv
module cbit_alu
  import cbit_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [4:0]      op_in,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic [IMMW-1:0] imm_in,
  input  logic            c_in,
  output logic [W-1:0]    res_out,
  output logic            res_vld,
  output logic            c_new,
  output logic            c_we
);

  logic [W-1:0] r_ar, r_bo, r_sh, r_mux;
  unit_flags_t  f_ar, f_bo, f_sh, f_mux;

  cbit_arith #(.W(W)) u_arith (
    .op(op_in), .a(a_in), .b(b_in), .cin(c_in), .res(r_ar), .flg(f_ar)
  );

  cbit_bitops #(.W(W), .IMMW(IMMW)) u_bitops (
    .op(op_in), .a(a_in), .bsel(b_in[IMMW:0]), .imm(imm_in),
    .res(r_bo), .flg(f_bo)
  );

  cbit_shift #(.W(W), .IMMW(IMMW)) u_shift (
    .op(op_in), .a(a_in), .imm(imm_in), .cin(c_in), .res(r_sh), .flg(f_sh)
  );

  // Units drive zero when they do not claim the code, so OR merges them.
  assign r_mux = r_ar | r_bo | r_sh;
  assign f_mux = f_ar | f_bo | f_sh;

  always_comb begin
    // R14
    units_exclusive_chk: assert ($onehot0({f_ar.own, f_bo.own, f_sh.own}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      res_vld <= 1'b0;
      c_new   <= 1'b0;
      c_we    <= 1'b0;
    end else begin
      res_out <= (issue && f_mux.rv) ? r_mux : '0;
      res_vld <= issue && f_mux.rv;
      c_we    <= issue && f_mux.cwe;
      c_new   <= (issue && f_mux.cwe) ? f_mux.c : c_in;
    end
  end

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !res_vld && !c_we && res_out == '0);

  // R4
  plain_add_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
    issue && (op_in == OP_ADDU || op_in == OP_SUBU) |=> res_vld && !c_we && c_new == $past(c_in));

  // R5
  compare_flag_only_chk: assert property (@(posedge clk) disable iff (rst)
    issue && (op_in == OP_CMPHS || op_in == OP_CMPLT) |=> c_we && !res_vld && res_out == '0);

  // R6
  xbyte_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    issue && op_in == OP_XBYTE |=> c_we && c_new == ($past(a_in) != '0) && res_out[W-1:8] == '0);

  // R11
  bitgen_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    issue && op_in == OP_BITGEN |=> $onehot0(res_out) && res_vld);

  // R12
  shrc_flag_in_chk: assert property (@(posedge clk) disable iff (rst)
    issue && op_in == OP_SHRC |=> res_out[W-1] == $past(c_in) && c_new == $past(a_in[0]));

  // R13
  bittst_chk: assert property (@(posedge clk) disable iff (rst)
    issue && op_in == OP_BITTST |=> c_we && !res_vld && c_new == $past(a_in[imm_in]));

  // R2
  addc_range_chk: assert property (@(posedge clk) disable iff (rst)
    issue && op_in == OP_ADDC && a_in == '0 && b_in == '0 |=> !c_new && res_out == W'($past(c_in)));

endmodule

// File: tb/sim_cbit_alu.sv
module sim_cbit_alu;

  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [4:0]  op_in = '0;
  logic [31:0] a_in = '0, b_in = '0;
  logic [4:0]  imm_in = '0;
  logic        c_in = 1'b0;
  logic [31:0] res_out;
  logic        res_vld, c_new, c_we;

  int nvec = 0;
  int nbad = 0;
  logic [31:0] pat [12];

  always #4 clk = ~clk;

  cbit_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .issue(issue), .op_in(op_in), .a_in(a_in),
    .b_in(b_in), .imm_in(imm_in), .c_in(c_in), .res_out(res_out),
    .res_vld(res_vld), .c_new(c_new), .c_we(c_we)
  );

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0: return "R2";
      5'd1: return "R3";
      5'd2, 5'd3: return "R4";
      5'd4, 5'd5: return "R5";
      5'd6: return "R6";
      5'd7: return "R7";
      5'd8, 5'd9, 5'd10: return "R8";
      5'd11: return "R9";
      5'd12: return "R10";
      5'd13, 5'd14: return "R11";
      5'd15, 5'd16: return "R12";
      5'd17: return "R13";
      default: return "R14";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] a, b,
                       input logic [4:0] imm, input logic cin,
                       output logic [31:0] r, output logic rv, cwe, c);
    logic [32:0] s;
    logic [31:0] d;
    int n;
    r = 0; rv = 0; cwe = 0; c = cin;
    case (op)
      5'd0: begin s = {1'b0, a} + {1'b0, b} + 33'(cin); r = s[31:0]; rv = 1; cwe = 1; c = s[32]; end
      5'd1: begin s = {1'b0, a} + {1'b0, ~b} + 33'(cin); r = a - b + 32'(cin) - 32'd1; rv = 1; cwe = 1; c = s[32]; end
      5'd2: begin r = a + b; rv = 1; end
      5'd3: begin r = a - b; rv = 1; end
      5'd4: begin cwe = 1; c = (a >= b); end
      5'd5: begin cwe = 1; c = ($signed(a) < $signed(b)); end
      5'd6: begin r = (a >> (8 * imm[1:0])) & 32'hFF; rv = 1; cwe = 1; c = (a != 0); end
      5'd7: begin cwe = 1; c = (a[31:24] != 0) && (a[23:16] != 0) && (a[15:8] != 0) && (a[7:0] != 0); end
      5'd8, 5'd9, 5'd10: begin
        d = a - 1; r = d; rv = 1; cwe = 1;
        if (op == 5'd8)      c = ($signed(d) < 0);
        else if (op == 5'd9) c = ($signed(d) > 0);
        else                 c = (d != 0);
      end
      5'd11: begin
        n = 0;
        while (n < 32 && a[31-n] == 1'b0) n++;
        r = 32'(n); rv = 1;
      end
      5'd12: begin for (int i = 0; i < 32; i++) r[31-i] = a[i]; rv = 1; end
      5'd13: begin r = b[5] ? 32'd0 : (32'd1 << b[4:0]); rv = 1; end
      5'd14: begin r = (imm == 0) ? 32'd0 : (32'hFFFF_FFFF >> (32 - int'(imm))); rv = 1; end
      5'd15: begin r = {cin, a[31:1]}; rv = 1; cwe = 1; c = a[0]; end
      5'd16: begin r = (imm == 0) ? a : ((a << imm) | (a >> (32 - int'(imm)))); rv = 1; end
      5'd17: begin cwe = 1; c = a[imm]; end
      default: ;
    endcase
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic apply(input logic [4:0] op, input logic [31:0] a, b,
                       input logic [4:0] imm, input logic cin);
    logic [31:0] er;
    logic erv, ecwe, ec;
    model(op, a, b, imm, cin, er, erv, ecwe, ec);
    issue = 1; op_in = op; a_in = a; b_in = b; imm_in = imm; c_in = cin;
    @(negedge clk);
    issue = 0;
    nvec++;
    if (res_out !== er || res_vld !== erv || c_new !== ec || c_we !== ecwe) begin
      nbad++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%0d cin=%0d: got res=%h vld=%b c=%b we=%b, expected res=%h vld=%b c=%b we=%b",
               req_of(op), op, a, b, imm, cin, res_out, res_vld, c_new, c_we, er, erv, ec, ecwe);
    end
  endtask

  task automatic idle_check(input logic cin);
    issue = 0; c_in = cin;
    @(negedge clk);
    nvec++;
    // R14: no issue gives quiet outputs and the flag passes through
    if (res_vld !== 0 || c_we !== 0 || res_out !== 0 || c_new !== cin) begin
      nbad++;
      $display("FAIL R14 idle: got res=%h vld=%b c=%b we=%b, expected res=0 vld=0 c=%b we=0",
               res_out, res_vld, c_new, c_we, cin);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL R14 watchdog expired: got hang, expected completion");
    finish_run();
  end

  initial begin
    pat = '{32'h0, 32'h1, 32'h2, 32'h20, 32'h25, 32'h3F, 32'h7FFF_FFFF,
            32'h8000_0000, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h1234_5678, 32'hFFFF_FFFE};
    repeat (3) @(negedge clk);
    c_in = 1;
    nvec++;
    // R1: outputs held at zero during reset
    if (res_out !== 0 || res_vld !== 0 || c_new !== 0 || c_we !== 0) begin
      nbad++;
      $display("FAIL R1 reset: got res=%h vld=%b c=%b we=%b, expected all 0", res_out, res_vld, c_new, c_we);
    end
    rst = 0;
    c_in = 0;
    idle_check(1'b1);
    idle_check(1'b0);

    // Every opcode code against the operand grid, both flag values.
    for (int op = 0; op < 32; op++)
      for (int ai = 0; ai < 12; ai++)
        for (int bi = 0; bi < 12; bi++)
          for (int ci = 0; ci < 2; ci++)
            apply(5'(op), pat[ai], pat[bi], 5'((ai * 5 + bi * 3 + ci * 11) % 32), ci[0]);

    // Full immediate sweeps: byte extract (R6), mask (R11), rotate (R12), bit test (R13).
    for (int ai = 0; ai < 12; ai++)
      for (int im = 0; im < 32; im++) begin
        apply(5'd6,  pat[ai], 32'h0, 5'(im), 1'b0);
        apply(5'd14, pat[ai], 32'h0, 5'(im), 1'b1);
        apply(5'd16, pat[ai], 32'h0, 5'(im), 1'b0);
        apply(5'd17, pat[ai], 32'h0, 5'(im), 1'b1);
      end

    // R11: bit-generate over every 6-bit selector, upper bits noisy.
    for (int bv = 0; bv < 64; bv++)
      apply(5'd13, 32'hDEAD_BEEF, 32'hABCD_EF00 | 32'(bv), 5'd0, 1'b0);

    // R9: single set bit at every position.
    for (int k = 0; k < 32; k++)
      apply(5'd11, 32'd1 << k, 32'h0, 5'd0, 1'b1);

    // R14: idle after activity and back-to-back issue.
    idle_check(1'b1);
    apply(5'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b0);
    apply(5'd1, 32'h0, 32'h1, 5'd0, 1'b1);
    idle_check(1'b0);

    finish_run();
  end

endmodule